// File: doc/BRIEF.md
# Fence Bypass Tracking Unit

This unit sits next to one core's write buffer. It lets loads that follow a memory fence retire while stores issued before the fence are still waiting to drain. The unit keeps a shadow copy of the line addresses held in the write buffer.

When a weak fence issues, the unit snapshots the undrained lines into a pending set, and other cores can query that set. Each later load is checked against the pending sets of the other threads, which the unit reaches through a remote lookup port. A remote hit stalls the load. A miss lets it retire, and its line is then recorded in a local bypass set. An incoming coherence write to a bypassed line is held back until the pre-fence stores have drained.

A strong fence behaves conventionally: loads wait for the drain, and no bypass set is built. The interval from a fence to the drain of its last earlier store is called an epoch. An epoch falls back to strong behaviour when either set would overflow, or when a second fence arrives while the epoch is still open. Every comparison is made on line addresses.

Top module: `fbt_fence_bypass`

## Requirements
- R1: After reset no epoch is open. A load (`rd_valid`) retires in the same cycle, a coherence write is acknowledged, `ext_hit` is 0 and `rmt_valid` is 0.
- R2: All comparisons use the line address, which is the byte address with its low 6 bits dropped (64-byte lines). Two byte addresses in the same line always match.
- R3: A weak fence captures the lines of every store still in the write buffer into the pending set. That set answers `ext_hit` for any address in those lines. A store pushed in the same cycle as the fence is post-fence and is not captured.
- R4: During a weak epoch a load raises `rmt_valid` with its line on `rmt_addr`. If `rmt_hit` is 1 the load stalls. Otherwise it retires, even though pre-fence stores are still undrained.
- R5: The line of a load that retires during a weak epoch enters the bypass set. A coherence write to a line in the bypass set gets `cw_stall` until the epoch closes. Coherence writes to other lines get `cw_ack`.
- R6: The epoch closes at the clock edge where its last pre-fence store drains. From the next cycle both sets are empty: `ext_hit` is 0, held coherence writes are acknowledged, and loads retire with `rmt_valid` at 0.
- R7: A strong fence stalls every load until all stores ahead of it have drained. It raises no remote query and creates neither set.
- R8: If a weak fence finds more than 8 undrained stores, its epoch runs as strong (R7 behaviour) and no pending set is captured.
- R9: A load whose line would be a ninth distinct bypass entry stalls, and the epoch turns strong from the next cycle. Existing bypass entries keep holding coherence writes until the epoch closes.
- R10: A fence issued while an epoch is open makes the epoch strong. The epoch then lasts until every store present at that second fence has drained.
- R11: A fence issued when the write buffer is empty opens no epoch, and loads keep retiring without a remote query.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_push | input | 1 | A store enters the write buffer |
| wb_push_addr | input | 32 | Byte address of that store |
| wb_drain | input | 1 | Oldest write-buffer store has completed |
| fence_valid | input | 1 | A fence issues this cycle |
| fence_strong | input | 1 | 1 selects a strong fence, 0 a weak one |
| rd_valid | input | 1 | A post-fence load asks to retire |
| rd_addr | input | 32 | Byte address of the load |
| rd_stall | output | 1 | Load must wait |
| rd_retire | output | 1 | Load may retire |
| rmt_valid | output | 1 | Query of the other cores' pending sets |
| rmt_addr | output | 26 | Line address queried |
| rmt_hit | input | 1 | Queried line is pending on another core |
| ext_addr | input | 32 | Byte address another core checks against this pending set |
| ext_hit | output | 1 | That line is in the local pending set |
| cw_valid | input | 1 | Incoming coherence write request |
| cw_addr | input | 32 | Byte address of that request |
| cw_stall | output | 1 | Request is held back |
| cw_ack | output | 1 | Request is acknowledged |

## Verification
The bench builds the unit with its default parameters: a 32-bit address, 64-byte lines, a 16-entry write-buffer shadow and 8-entry sets. With these values, nine queued stores are enough to overflow the pending set, and nine distinct loads are enough to exhaust the bypass set. Both fallbacks to strong behaviour are therefore reached within a few dozen cycles, alongside the same-cycle push at a fence and a second fence inside an open epoch.

// File: rtl/fbt_pkg.sv
package fbt_pkg;

    localparam int FBT_ADDR_W     = 32;
    localparam int FBT_LINE_BYTES = 64;
    localparam int FBT_SET_N      = 8;
    localparam int FBT_WB_DEPTH   = 16;

    // Epoch state: no fence outstanding, bypassing allowed, or conventional wait.
    typedef enum logic [1:0] {
        EP_NONE   = 2'd0,
        EP_WEAK   = 2'd1,
        EP_STRONG = 2'd2
    } ep_mode_e;

    // Verdict for one load request.
    typedef enum logic [1:0] {
        RD_IDLE   = 2'd0,
        RD_RETIRE = 2'd1,
        RD_STALL  = 2'd2
    } rd_verdict_e;

    // Control decided for the next cycle.
    typedef struct packed {
        ep_mode_e mode;
        logic     ps_load;
        logic     go_strong;
    } ep_step_t;

endpackage

// File: rtl/fbt_wb_shadow.sv
module fbt_wb_shadow #(
    parameter int DEPTH = 16,
    parameter int W     = 26,
    parameter int SNAP  = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int OW    = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   push,
    input  logic [W-1:0]           push_line,
    input  logic                   drain,
    output logic                   drain_ok,
    output logic [OW-1:0]          occ,
    output logic [OW-1:0]          occ_eff,
    output logic [SNAP-1:0][W-1:0] snap
);

    logic [DEPTH-1:0][W-1:0] mem;
    logic [PTR_W-1:0]        rd_ptr, wr_ptr;
    logic                    push_ok;

    assign drain_ok = drain && (occ != '0);
    assign push_ok  = push && (occ < OW'(DEPTH));
    // Stores still waiting once this cycle's drain is counted.
    assign occ_eff  = occ - OW'(drain_ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            occ    <= '0;
        end else begin
            if (push_ok) begin
                mem[wr_ptr] <= push_line;
                wr_ptr      <= wr_ptr + PTR_W'(1);
            end
            if (drain_ok)
                rd_ptr <= rd_ptr + PTR_W'(1);
            occ <= occ + OW'(push_ok) - OW'(drain_ok);
        end
    end

    // Oldest surviving stores, oldest first.
    always_comb begin
        for (int i = 0; i < SNAP; i++) begin
            logic [PTR_W-1:0] idx;
            idx     = rd_ptr + PTR_W'(i) + PTR_W'(drain_ok);
            snap[i] = mem[idx];
        end
    end

    a_r3_occ_bound: assert property (@(posedge clk) disable iff (rst)
        occ <= OW'(DEPTH));

    a_r3_occ_step: assert property (@(posedge clk) disable iff (rst)
        (drain_ok && !push_ok) |=> occ == $past(occ) - OW'(1));

endmodule

// File: rtl/fbt_line_set.sv
module fbt_line_set #(
    parameter int N  = 8,
    parameter int W  = 26,
    parameter int NL = 1,
    localparam int CW = $clog2(N + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 ld,
    input  logic [CW-1:0]        ld_cnt,
    input  logic [N-1:0][W-1:0]  ld_addr,
    input  logic                 ins,
    input  logic [W-1:0]         ins_addr,
    input  logic [NL-1:0][W-1:0] look_addr,
    output logic [NL-1:0]        look_hit,
    output logic                 full
);

    logic [N-1:0][W-1:0] mem;
    logic [CW-1:0]       cnt;
    logic [N-1:0]        vld;

    assign full = (cnt == CW'(N));

    generate
        for (genvar i = 0; i < N; i++) begin : g_ent
            assign vld[i] = CW'(i) < cnt;
            always_ff @(posedge clk) begin
                if (ld)
                    mem[i] <= ld_addr[i];
                else if (!clr && ins && cnt == CW'(i))
                    mem[i] <= ins_addr;
            end
        end
        for (genvar k = 0; k < NL; k++) begin : g_look
            always_comb begin
                look_hit[k] = 1'b0;
                for (int j = 0; j < N; j++)
                    if (vld[j] && mem[j] == look_addr[k])
                        look_hit[k] = 1'b1;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (ld)
            cnt <= ld_cnt;
        else if (clr)
            cnt <= '0;
        else if (ins && !full)
            cnt <= cnt + CW'(1);
    end

    a_r9_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(N));

    a_r9_no_ins_full: assert property (@(posedge clk) disable iff (rst)
        ins |-> !full);

    a_r6_clr_empties: assert property (@(posedge clk) disable iff (rst)
        (clr && !ld) |=> look_hit == '0);

endmodule

// File: rtl/fbt_fence_bypass.sv
module fbt_fence_bypass
    import fbt_pkg::*;
#(
    parameter int ADDR_W     = FBT_ADDR_W,
    parameter int LINE_BYTES = FBT_LINE_BYTES,
    parameter int SET_N      = FBT_SET_N,
    parameter int WB_DEPTH   = FBT_WB_DEPTH,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int LINE_W = ADDR_W - OFF_W,
    localparam int OW     = $clog2(WB_DEPTH + 1),
    localparam int CW     = $clog2(SET_N + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wb_push,
    input  logic [ADDR_W-1:0] wb_push_addr,
    input  logic              wb_drain,
    input  logic              fence_valid,
    input  logic              fence_strong,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_stall,
    output logic              rd_retire,
    output logic              rmt_valid,
    output logic [LINE_W-1:0] rmt_addr,
    input  logic              rmt_hit,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic              ext_hit,
    input  logic              cw_valid,
    input  logic [ADDR_W-1:0] cw_addr,
    output logic              cw_stall,
    output logic              cw_ack
);

    logic [LINE_W-1:0] rd_line, cw_line, ext_line, push_line;
    assign rd_line   = rd_addr[ADDR_W-1:OFF_W];
    assign cw_line   = cw_addr[ADDR_W-1:OFF_W];
    assign ext_line  = ext_addr[ADDR_W-1:OFF_W];
    assign push_line = wb_push_addr[ADDR_W-1:OFF_W];

    logic unused_lo;
    assign unused_lo = ^{rd_addr[OFF_W-1:0], cw_addr[OFF_W-1:0],
                         ext_addr[OFF_W-1:0], wb_push_addr[OFF_W-1:0]};

    // Write-buffer shadow.
    logic                         drain_ok;
    logic [OW-1:0]                occ, occ_eff;
    logic [SET_N-1:0][LINE_W-1:0] snap;

    fbt_wb_shadow #(.DEPTH(WB_DEPTH), .W(LINE_W), .SNAP(SET_N)) u_shadow (
        .clk(clk), .rst(rst), .push(wb_push), .push_line(push_line),
        .drain(wb_drain), .drain_ok(drain_ok), .occ(occ), .occ_eff(occ_eff),
        .snap(snap)
    );

    // Epoch state.
    ep_mode_e      mode_q;
    logic [OW-1:0] pre_q;
    logic          closing, live;
    ep_step_t      step;
    logic [OW-1:0] pre_d;

    assign closing = (mode_q != EP_NONE) && drain_ok && (pre_q == OW'(1));
    assign live    = (mode_q != EP_NONE) && !closing;

    // Pending set (lookup from other cores) and bypass set (cw, rd).
    logic                         ps_hit, bs_full, bs_ins;
    logic [1:0]                   bs_hit;
    logic                         ps_full_unused;

    fbt_line_set #(.N(SET_N), .W(LINE_W), .NL(1)) u_pend (
        .clk(clk), .rst(rst), .clr(closing), .ld(step.ps_load),
        .ld_cnt(CW'(occ_eff)), .ld_addr(snap), .ins(1'b0), .ins_addr('0),
        .look_addr(ext_line), .look_hit(ps_hit), .full(ps_full_unused)
    );

    fbt_line_set #(.N(SET_N), .W(LINE_W), .NL(2)) u_byp (
        .clk(clk), .rst(rst), .clr(closing), .ld(1'b0), .ld_cnt('0),
        .ld_addr('0), .ins(bs_ins), .ins_addr(rd_line),
        .look_addr({rd_line, cw_line}), .look_hit(bs_hit), .full(bs_full)
    );

    // Load verdict.
    rd_verdict_e verdict;
    logic        go_strong;

    always_comb begin
        verdict   = RD_IDLE;
        bs_ins    = 1'b0;
        go_strong = 1'b0;
        if (rd_valid) begin
            unique case (mode_q)
                EP_WEAK: begin
                    if (rmt_hit) begin
                        verdict = RD_STALL;
                    end else if (bs_hit[1]) begin
                        verdict = RD_RETIRE;
                    end else if (!bs_full) begin
                        verdict = RD_RETIRE;
                        bs_ins  = 1'b1;
                    end else begin
                        verdict   = RD_STALL;
                        go_strong = 1'b1;
                    end
                end
                EP_STRONG: verdict = RD_STALL;
                default:   verdict = RD_RETIRE;
            endcase
        end
    end

    assign rd_stall  = (verdict == RD_STALL);
    assign rd_retire = (verdict == RD_RETIRE);
    assign rmt_valid = rd_valid && (mode_q == EP_WEAK);
    assign rmt_addr  = rd_line;
    assign ext_hit   = ps_hit;
    assign cw_stall  = cw_valid && bs_hit[0];
    assign cw_ack    = cw_valid && !bs_hit[0];

    // Next epoch state.
    always_comb begin
        step.mode      = mode_q;
        step.ps_load   = 1'b0;
        step.go_strong = go_strong;
        pre_d          = pre_q;
        if (closing) begin
            step.mode = EP_NONE;
            pre_d     = '0;
        end else if (mode_q != EP_NONE && drain_ok) begin
            pre_d = pre_q - OW'(1);
        end
        if (step.go_strong && !closing)
            step.mode = EP_STRONG;
        if (fence_valid) begin
            if (live) begin
                step.mode = EP_STRONG;
                pre_d     = occ_eff;
            end else if (occ_eff != '0) begin
                pre_d = occ_eff;
                if (fence_strong || occ_eff > OW'(SET_N)) begin
                    step.mode = EP_STRONG;
                end else begin
                    step.mode    = EP_WEAK;
                    step.ps_load = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= EP_NONE;
            pre_q  <= '0;
        end else begin
            mode_q <= step.mode;
            pre_q  <= pre_d;
        end
    end

    a_r3_pre_within_buffer: assert property (@(posedge clk) disable iff (rst)
        (mode_q != EP_NONE) |-> (pre_q != '0 && pre_q <= occ));

    a_r5_cw_hold_in_epoch: assert property (@(posedge clk) disable iff (rst)
        cw_stall |-> mode_q != EP_NONE);

    a_r6_ext_in_epoch: assert property (@(posedge clk) disable iff (rst)
        ext_hit |-> mode_q != EP_NONE);

    a_r7_strong_no_retire: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && mode_q == EP_STRONG) |-> rd_stall);

    a_r10_strong_sticks: assert property (@(posedge clk) disable iff (rst)
        (mode_q == EP_STRONG && !closing) |=> mode_q != EP_WEAK);

    a_r4_answer_onehot: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $onehot({rd_stall, rd_retire}));

endmodule

// File: tb/fbt_fence_bypass_test.sv
module fbt_fence_bypass_test;

    localparam int HALF = 10;  // 50 MHz

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wb_push, wb_drain, fence_valid, fence_strong;
    logic        rd_valid, rmt_hit, cw_valid;
    logic [31:0] wb_push_addr, rd_addr, ext_addr, cw_addr;
    logic        rd_stall, rd_retire, rmt_valid, ext_hit, cw_stall, cw_ack;
    logic [25:0] rmt_addr;

    always #HALF clk = ~clk;

    fbt_fence_bypass uut (
        .clk(clk), .rst(rst), .wb_push(wb_push), .wb_push_addr(wb_push_addr),
        .wb_drain(wb_drain), .fence_valid(fence_valid), .fence_strong(fence_strong),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_stall(rd_stall),
        .rd_retire(rd_retire), .rmt_valid(rmt_valid), .rmt_addr(rmt_addr),
        .rmt_hit(rmt_hit), .ext_addr(ext_addr), .ext_hit(ext_hit),
        .cw_valid(cw_valid), .cw_addr(cw_addr), .cw_stall(cw_stall), .cw_ack(cw_ack)
    );

    // Vector bits: {rd_stall, rd_retire, cw_stall, cw_ack, ext_hit, rmt_valid}
    localparam logic [5:0] M_RD  = 6'b110000;
    localparam logic [5:0] M_CW  = 6'b001100;
    localparam logic [5:0] M_EXT = 6'b000010;
    localparam logic [5:0] M_RMT = 6'b000001;

    typedef struct {
        string      req;
        logic [5:0] exp;
        logic [5:0] mask;
    } item_t;

    item_t q[$];
    int    n_vec  = 0;
    int    n_miss = 0;
    bit    done   = 1'b0;

    // Staged stimulus for the next cycle.
    logic        s_push, s_drain, s_fence, s_fstrong, s_rd, s_rhit, s_cw;
    logic [31:0] s_paddr, s_raddr, s_caddr, s_eaddr;

    function automatic logic [31:0] ln(int line, int off);
        return 32'(line * 64 + off);
    endfunction

    task automatic stage_idle();
        s_push = 0; s_drain = 0; s_fence = 0; s_fstrong = 0;
        s_rd = 0; s_rhit = 0; s_cw = 0;
        s_paddr = 0; s_raddr = 0; s_caddr = 0; s_eaddr = 0;
    endtask

    // Driver: apply staged inputs at a falling edge, push the expectation.
    task automatic tick(string req, logic [5:0] exp, logic [5:0] mask);
        item_t it;
        @(negedge clk);
        wb_push = s_push; wb_push_addr = s_paddr; wb_drain = s_drain;
        fence_valid = s_fence; fence_strong = s_fstrong;
        rd_valid = s_rd; rd_addr = s_raddr; rmt_hit = s_rhit;
        cw_valid = s_cw; cw_addr = s_caddr; ext_addr = s_eaddr;
        it.req = req; it.exp = exp; it.mask = mask;
        q.push_back(it);
        stage_idle();
    endtask

    // Monitor: mid-cycle compare, a quarter period before the rising edge.
    initial begin
        forever begin
            @(negedge clk);
            #(HALF / 2);
            while (q.size() > 0) begin
                item_t it;
                logic [5:0] act;
                it  = q.pop_front();
                act = {rd_stall, rd_retire, cw_stall, cw_ack, ext_hit, rmt_valid};
                if (it.mask != 0) begin
                    n_vec++;
                    if ((act & it.mask) !== (it.exp & it.mask)) begin
                        n_miss++;
                        $display("FAIL %s: actual %b expected %b (mask %b)",
                                 it.req, act, it.exp, it.mask);
                    end
                end
            end
        end
    end

    initial begin
        #(2 * HALF * 5000);
        if (!done) begin
            n_miss++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end

    initial begin
        stage_idle();
        wb_push = 0; wb_push_addr = 0; wb_drain = 0; fence_valid = 0; fence_strong = 0;
        rd_valid = 0; rd_addr = 0; rmt_hit = 0; cw_valid = 0; cw_addr = 0; ext_addr = 0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        s_rd = 1; s_raddr = ln(5, 0); s_rhit = 1; s_cw = 1; s_caddr = ln(5, 0); s_eaddr = ln(5, 0);
        tick("R1", 6'b010100, M_RD | M_CW | M_EXT | M_RMT);

        // Weak epoch: two stores, fence with a same-cycle third store
        s_push = 1; s_paddr = ln(16, 0);  tick("", 0, 0);
        s_push = 1; s_paddr = ln(17, 5);  tick("", 0, 0);
        s_push = 1; s_paddr = ln(18, 0); s_fence = 1; tick("", 0, 0);
        s_eaddr = ln(16, 63);             tick("R3 R2 pending line", 6'b000010, M_EXT);
        s_eaddr = ln(17, 0);              tick("R3 second pending line", 6'b000010, M_EXT);
        s_eaddr = ln(18, 0);              tick("R3 same-cycle push excluded", 6'b000000, M_EXT);
        s_rd = 1; s_raddr = ln(32, 0); s_rhit = 1;
        tick("R4 remote hit stalls", 6'b100001, M_RD | M_RMT);
        s_rd = 1; s_raddr = ln(33, 8); s_rhit = 0;
        tick("R4 remote miss retires", 6'b010001, M_RD | M_RMT);
        s_cw = 1; s_caddr = ln(33, 40);   tick("R5 R2 bypassed line held", 6'b001000, M_CW);
        s_cw = 1; s_caddr = ln(34, 0);    tick("R5 other line acked", 6'b000100, M_CW);
        s_drain = 1; s_cw = 1; s_caddr = ln(33, 0);
        tick("R5 held after first drain", 6'b001000, M_CW);
        s_drain = 1; s_cw = 1; s_caddr = ln(33, 0);
        tick("R6 held in closing cycle", 6'b001000, M_CW);
        s_cw = 1; s_caddr = ln(33, 0); s_eaddr = ln(16, 0); s_rd = 1; s_raddr = ln(48, 0); s_rhit = 1;
        tick("R6 epoch closed", 6'b010100, M_RD | M_CW | M_EXT | M_RMT);
        s_drain = 1; tick("", 0, 0);

        // Strong fence
        s_push = 1; s_paddr = ln(64, 0); tick("", 0, 0);
        s_fence = 1; s_fstrong = 1;      tick("", 0, 0);
        s_rd = 1; s_raddr = ln(80, 0); s_eaddr = ln(64, 0);
        tick("R7 strong stalls, no query, no pending", 6'b100000, M_RD | M_EXT | M_RMT);
        s_cw = 1; s_caddr = ln(80, 0);   tick("R7 no bypass set", 6'b000100, M_CW);
        s_drain = 1; s_rd = 1; s_raddr = ln(80, 0);
        tick("R7 stall until drained", 6'b100000, M_RD);
        s_rd = 1; s_raddr = ln(80, 0);   tick("R7 retire after drain", 6'b010000, M_RD | M_RMT);

        // Fence with empty buffer
        s_fence = 1; tick("", 0, 0);
        s_rd = 1; s_raddr = ln(81, 0); s_rhit = 1;
        tick("R11 no epoch", 6'b010000, M_RD | M_RMT);

        // Pending-set overflow
        for (int k = 0; k < 9; k++) begin
            s_push = 1; s_paddr = ln(96 + k, 0); tick("", 0, 0);
        end
        s_fence = 1; tick("", 0, 0);
        s_rd = 1; s_raddr = ln(120, 0); s_eaddr = ln(96, 0);
        tick("R8 overflow falls back to strong", 6'b100000, M_RD | M_EXT | M_RMT);
        for (int k = 0; k < 9; k++) begin
            s_drain = 1; tick("", 0, 0);
        end
        s_rd = 1; s_raddr = ln(120, 0);  tick("R8 retire after drain", 6'b010000, M_RD);

        // Bypass-set overflow
        s_push = 1; s_paddr = ln(112, 0); tick("", 0, 0);
        s_fence = 1; tick("", 0, 0);
        for (int k = 0; k < 8; k++) begin
            s_rd = 1; s_raddr = ln(128 + k, 0);
            tick("R9 bypass entry retires", 6'b010001, M_RD | M_RMT);
        end
        s_rd = 1; s_raddr = ln(136, 0);  tick("R9 ninth line stalls", 6'b100001, M_RD | M_RMT);
        s_rd = 1; s_raddr = ln(128, 0); s_cw = 1; s_caddr = ln(131, 0);
        tick("R9 epoch now strong, entries kept", 6'b101000, M_RD | M_CW | M_RMT);
        s_drain = 1; tick("", 0, 0);
        s_rd = 1; s_raddr = ln(128, 0); s_cw = 1; s_caddr = ln(131, 0);
        tick("R9 released at close", 6'b010100, M_RD | M_CW);

        // Second fence inside an open epoch
        s_push = 1; s_paddr = ln(144, 0); tick("", 0, 0);
        s_fence = 1; tick("", 0, 0);
        s_push = 1; s_paddr = ln(145, 0); tick("", 0, 0);
        s_fence = 1; tick("", 0, 0);
        s_rd = 1; s_raddr = ln(160, 0);  tick("R10 second fence strong", 6'b100000, M_RD | M_RMT);
        s_drain = 1; s_rd = 1; s_raddr = ln(160, 0); tick("R10 first drain", 6'b100000, M_RD);
        s_rd = 1; s_raddr = ln(160, 0);  tick("R10 waits for later store", 6'b100000, M_RD);
        s_drain = 1; tick("", 0, 0);
        s_rd = 1; s_raddr = ln(160, 0);  tick("R10 retire after all drained", 6'b010000, M_RD | M_RMT);

        tick("", 0, 0);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

endmodule